// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits next to a simple program counter and runs short instruction loops without any software compare or branch. A setup strobe carries the first address of the loop body, the last address and the number of passes. From then on the block compares the current fetch address with the loop's last address in the same cycle as the fetch. When more passes remain, it tells the program counter to take an override address (the body's first address) as the next fetch, so the jump back costs no cycle. The pass counter is decremented in hardware at every loop-back.

The program counter logic takes `pc_target` when `pc_redirect` is high and otherwise steps to `fetch_pc + 1`. Loop state is kept as a small stack (two levels by default), so a loop can be set up inside another one. When the inner loop retires, the outer loop continues with the passes it had left. If the inner and outer loops end on the same address, both levels are tested in that one cycle. A setup strobe takes priority over the end-address test in the cycle where it is asserted.

Top module: `hwl_loop_seq`

## Requirements
- R1: After reset no loop is armed: `loop_active` is 0 and `pc_redirect` is 0 whatever the fetch address.
- R2: A setup with a nonzero count drives `pc_redirect`=1 with `pc_target` equal to the body start in the setup cycle, and `loop_active` is 1 from the next cycle on.
- R3: While a loop is armed and the fetch address equals its last address with more than one pass left, `pc_redirect` is 1 and `pc_target` is the body start in that same cycle, and the pass count drops by one. The body therefore runs exactly count times, with the fetch of the start address following the end address with no gap cycle.
- R4: On the final pass (remaining count 1) at the last address there is no redirect, so fetch continues at end+1. With one level armed, `loop_active` is 0 from the next cycle.
- R5: A setup with count 0 redirects fetch to end+1 in the setup cycle, skips the body entirely and arms nothing.
- R6: A nonzero setup while one loop is armed saves the outer loop. After the inner loop retires, the outer loop resumes with the count it had left.
- R7: When the inner loop's final pass ends on an address that is also the saved outer loop's last address, the outer loop is tested in the same cycle. If the outer loop has more than one pass left, fetch is redirected to the outer start and the outer count is decremented. Otherwise both levels retire and fetch falls through.
- R8: A nonzero setup while DEPTH levels are armed is ignored: no redirect, and the stored loops are unchanged.
- R9: A single-instruction loop (start equal to end) repeats that instruction count times back to back, for counts well above the stack depth (for example 40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_vld | input | 1 | Loop setup strobe, one cycle |
| setup_start | input | ADDR_W | First address of the loop body |
| setup_end | input | ADDR_W | Last address of the loop body |
| setup_count | input | CNT_W | Number of passes (0 skips the body) |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pc_redirect | output | 1 | Next fetch takes `pc_target` instead of `fetch_pc + 1` |
| pc_target | output | ADDR_W | Override address for the next fetch |
| loop_active | output | 1 | At least one loop level is armed |

## Verification
A wrong pass count shows up at the ports as extra or missing fetches of the loop body. This appears at the first final pass, which comes within count × body length cycles of the setup. A stack entry that is wrongly saved or restored becomes visible when the inner loop retires: the outer loop either jumps to the wrong address or stops repeating on its next end-address fetch. For that reason the bench closes the loop through its own program counter and checks visit counts per address, total fetch cycles and the active-cycle count against values worked out from the requirements.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

  // Stack operation chosen by the decision logic for the coming clock edge
  typedef enum logic [2:0] {
    OP_NONE,     // no change
    OP_PUSH,     // arm a new level
    OP_DEC,      // loop back, one pass used
    OP_POP,      // innermost level retires
    OP_POP_DEC,  // inner retires, outer loops back on the shared end
    OP_POP2      // inner and outer retire together on the shared end
  } hwl_op_e;

endpackage

// File: rtl/hwl_stack.sv
module hwl_stack
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DEPTH  = 2,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hwl_op_e           op,
  input  logic [ADDR_W-1:0] push_start,
  input  logic [ADDR_W-1:0] push_end,
  input  logic [CNT_W-1:0]  push_cnt,
  output logic [ADDR_W-1:0] top_start,
  output logic [ADDR_W-1:0] top_end,
  output logic [CNT_W-1:0]  top_cnt,
  output logic [ADDR_W-1:0] nxt_start,
  output logic [ADDR_W-1:0] nxt_end,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic [LVL_W-1:0]  lvl,
  output logic              has_top,
  output logic              has_below,
  output logic              full
);

  function automatic logic [CNT_W-1:0] cnt_minus1(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] lvl_to_idx(input logic [LVL_W-1:0] l);
    return IDX_W'(l);
  endfunction

  logic [LVL_W-1:0]  lvl_q;
  logic [IDX_W-1:0]  top_idx;
  logic [IDX_W-1:0]  below_idx;
  logic [ADDR_W-1:0] st_w  [DEPTH];
  logic [ADDR_W-1:0] en_w  [DEPTH];
  logic [CNT_W-1:0]  cn_w  [DEPTH];

  assign top_idx   = lvl_to_idx(lvl_q - LVL_W'(1));
  assign below_idx = lvl_to_idx(lvl_q - LVL_W'(2));

  // One storage slot per nesting level
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ADDR_W-1:0] s_q;
    logic [ADDR_W-1:0] e_q;
    logic [CNT_W-1:0]  c_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        e_q <= '0;
        c_q <= '0;
      end else begin
        if (op == OP_PUSH && lvl_q == LVL_W'(i)) begin
          s_q <= push_start;
          e_q <= push_end;
          c_q <= push_cnt;
        end
        if (op == OP_DEC && top_idx == IDX_W'(i)) begin
          c_q <= cnt_minus1(c_q);
        end
        if (op == OP_POP_DEC && below_idx == IDX_W'(i)) begin
          c_q <= cnt_minus1(c_q);
        end
      end
    end

    assign st_w[i] = s_q;
    assign en_w[i] = e_q;
    assign cn_w[i] = c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      unique case (op)
        OP_PUSH:            lvl_q <= lvl_q + LVL_W'(1);
        OP_POP, OP_POP_DEC: lvl_q <= lvl_q - LVL_W'(1);
        OP_POP2:            lvl_q <= lvl_q - LVL_W'(2);
        default:            lvl_q <= lvl_q;
      endcase
    end
  end

  assign top_start = st_w[top_idx];
  assign top_end   = en_w[top_idx];
  assign top_cnt   = cn_w[top_idx];
  assign nxt_start = st_w[below_idx];
  assign nxt_end   = en_w[below_idx];
  assign nxt_cnt   = cn_w[below_idx];
  assign lvl       = lvl_q;
  assign has_top   = (lvl_q != '0);
  assign has_below = (lvl_q >= LVL_W'(2));
  assign full      = (lvl_q == LVL_W'(DEPTH));

  // R8
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC) |=> (top_cnt == $past(top_cnt) - CNT_W'(1)));

  // R2
  live_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_top |-> (top_cnt != '0));

  // R6
  push_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && has_top) |=> (nxt_cnt == $past(top_cnt) && nxt_start == $past(top_start)));

endmodule

// File: rtl/hwl_match.sv
module hwl_match
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              setup_vld,
  input  logic [ADDR_W-1:0] setup_start,
  input  logic [ADDR_W-1:0] setup_end,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              has_top,
  input  logic              has_below,
  input  logic              full,
  input  logic [ADDR_W-1:0] top_start,
  input  logic [ADDR_W-1:0] top_end,
  input  logic [CNT_W-1:0]  top_cnt,
  input  logic [ADDR_W-1:0] nxt_start,
  input  logic [ADDR_W-1:0] nxt_end,
  input  logic [CNT_W-1:0]  nxt_cnt,
  output hwl_op_e           op,
  output logic              redirect,
  output logic [ADDR_W-1:0] target,
  output logic              at_end,
  output logic              last_pass,
  output logic              shared_end
);

  function automatic logic is_final(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic has_more(input logic [CNT_W-1:0] c);
    return c > CNT_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] after(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // Named events, brought out for the checks in the top level
  assign at_end     = has_top && (fetch_pc == top_end);
  assign last_pass  = at_end && is_final(top_cnt);
  assign shared_end = last_pass && has_below && (nxt_end == fetch_pc);

  always_comb begin
    op       = OP_NONE;
    redirect = 1'b0;
    target   = top_start;
    if (setup_vld) begin
      if (setup_count == '0) begin
        redirect = 1'b1;
        target   = after(setup_end);
      end else if (!full) begin
        op       = OP_PUSH;
        redirect = 1'b1;
        target   = setup_start;
      end
    end else if (at_end) begin
      if (!last_pass) begin
        op       = OP_DEC;
        redirect = 1'b1;
        target   = top_start;
      end else if (shared_end) begin
        if (has_more(nxt_cnt)) begin
          op       = OP_POP_DEC;
          redirect = 1'b1;
          target   = nxt_start;
        end else begin
          op = OP_POP2;
        end
      end else begin
        op = OP_POP;
      end
    end
  end

endmodule

// File: rtl/hwl_loop_seq.sv
module hwl_loop_seq
  import hwl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int DEPTH  = 2,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_vld,
  input  logic [ADDR_W-1:0] setup_start,
  input  logic [ADDR_W-1:0] setup_end,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pc_redirect,
  output logic [ADDR_W-1:0] pc_target,
  output logic              loop_active
);

  hwl_op_e           op;
  logic [ADDR_W-1:0] top_start, top_end, nxt_start, nxt_end;
  logic [CNT_W-1:0]  top_cnt, nxt_cnt;
  logic [LVL_W-1:0]  lvl;
  logic              has_top, has_below, full;
  logic              at_end, last_pass, shared_end;

  hwl_stack #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .push_start(setup_start),
    .push_end  (setup_end),
    .push_cnt  (setup_count),
    .top_start (top_start),
    .top_end   (top_end),
    .top_cnt   (top_cnt),
    .nxt_start (nxt_start),
    .nxt_end   (nxt_end),
    .nxt_cnt   (nxt_cnt),
    .lvl       (lvl),
    .has_top   (has_top),
    .has_below (has_below),
    .full      (full)
  );

  hwl_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
    .setup_vld  (setup_vld),
    .setup_start(setup_start),
    .setup_end  (setup_end),
    .setup_count(setup_count),
    .fetch_pc   (fetch_pc),
    .has_top    (has_top),
    .has_below  (has_below),
    .full       (full),
    .top_start  (top_start),
    .top_end    (top_end),
    .top_cnt    (top_cnt),
    .nxt_start  (nxt_start),
    .nxt_end    (nxt_end),
    .nxt_cnt    (nxt_cnt),
    .op         (op),
    .redirect   (pc_redirect),
    .target     (pc_target),
    .at_end     (at_end),
    .last_pass  (last_pass),
    .shared_end (shared_end)
  );

  assign loop_active = has_top;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active && !setup_vld) |-> !pc_redirect);

  // R3
  loopback_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !last_pass && !setup_vld) |=> loop_active);

  // R4
  final_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pass && !setup_vld && lvl == LVL_W'(1)) |=> !loop_active);

  // R5
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_vld && setup_count == '0) |=> $stable(lvl));

  // R7
  shared_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_end && !setup_vld) |=> (lvl < $past(lvl)));

  // R8
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_vld && full && setup_count != '0) |=> $stable(lvl));

endmodule

// File: tb/sim_hwl_loop_seq.sv
`timescale 1ns/1ps
module sim_hwl_loop_seq;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              setup_vld = 1'b0;
  logic [ADDR_W-1:0] setup_start = '0;
  logic [ADDR_W-1:0] setup_end = '0;
  logic [CNT_W-1:0]  setup_count = '0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              pc_redirect;
  logic [ADDR_W-1:0] pc_target;
  logic              loop_active;

  int checks = 0;
  int fails  = 0;

  // program description: up to three setup instructions
  int sa[3], ss[3], se[3], sc[3];
  int visits[64];
  int cycles, loopbacks, act_cyc, setup_tgt, end_active;

  always #10 clk = ~clk;

  hwl_loop_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .setup_vld(setup_vld), .setup_start(setup_start),
    .setup_end(setup_end), .setup_count(setup_count), .fetch_pc(fetch_pc),
    .pc_redirect(pc_redirect), .pc_target(pc_target), .loop_active(loop_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int k, input int a, input int s, input int e, input int c);
    sa[k] = a; ss[k] = s; se[k] = e; sc[k] = c;
  endtask

  // Closed-loop fetch: the bench's own PC follows the redirect outputs
  task automatic run_prog(input int nset, input int stop);
    int pc;
    bit done;
    pc = 0; done = 0;
    cycles = 0; loopbacks = 0; act_cyc = 0; setup_tgt = -1; end_active = -1;
    for (int i = 0; i < 64; i++) visits[i] = 0;
    while (!done) begin
      @(negedge clk);
      fetch_pc  = ADDR_W'(pc);
      setup_vld = 1'b0;
      for (int k = 0; k < nset; k++) begin
        if (sa[k] == pc) begin
          setup_vld   = 1'b1;
          setup_start = ADDR_W'(ss[k]);
          setup_end   = ADDR_W'(se[k]);
          setup_count = CNT_W'(sc[k]);
        end
      end
      #1;
      if (pc == stop) begin
        end_active = int'(loop_active);
        done = 1;
      end else begin
        if (pc < 64) visits[pc]++;
        cycles++;
        if (loop_active) act_cyc++;
        if (pc_redirect && !setup_vld) loopbacks++;
        if (setup_vld) setup_tgt = pc_redirect ? int'(pc_target) : -1;
        pc = pc_redirect ? int'(pc_target) : pc + 1;
        if (cycles > 2000) begin
          chk("run watchdog", cycles, 0);
          done = 1;
        end
      end
    end
    @(negedge clk);
    setup_vld = 1'b0;
  endtask

  task automatic t_reset;
    fetch_pc = 16'd7;
    #1;
    chk("R1 redirect after reset", int'(pc_redirect), 0);
    chk("R1 loop_active after reset", int'(loop_active), 0);
  endtask

  task automatic t_single;
    cfg(0, 4, 5, 7, 3);
    run_prog(1, 9);
    chk("R2 setup target", setup_tgt, 5);
    chk("R2 active cycles", act_cyc, 9);
    chk("R3 body start visits", visits[5], 3);
    chk("R3 end visits", visits[7], 3);
    chk("R3 loop-backs", loopbacks, 2);
    chk("R3 no-bubble cycle total", cycles, 15);
    chk("R4 fall-through visit", visits[8], 1);
    chk("R4 active dropped", end_active, 0);
  endtask

  task automatic t_once;
    cfg(0, 4, 5, 7, 1);
    run_prog(1, 9);
    chk("R4 count1 body visits", visits[5], 1);
    chk("R4 count1 loop-backs", loopbacks, 0);
    chk("R4 count1 cycles", cycles, 9);
    chk("R4 count1 active dropped", end_active, 0);
  endtask

  task automatic t_zero;
    cfg(0, 4, 5, 7, 0);
    run_prog(1, 9);
    chk("R5 skip target", setup_tgt, 8);
    chk("R5 body not fetched", visits[5] + visits[6] + visits[7], 0);
    chk("R5 after-end visit", visits[8], 1);
    chk("R5 never active", act_cyc, 0);
    chk("R5 cycles", cycles, 6);
  endtask

  task automatic t_nested;
    cfg(0, 2, 3, 12, 2);
    cfg(1, 5, 6, 8, 3);
    run_prog(2, 13);
    chk("R6 inner start visits", visits[6], 6);
    chk("R6 inner end visits", visits[8], 6);
    chk("R6 outer resumes after inner", visits[9], 2);
    chk("R6 outer end visits", visits[12], 2);
    chk("R6 outer start visits", visits[3], 2);
    chk("R6 cycles", cycles, 35);
    chk("R6 active dropped", end_active, 0);
  endtask

  task automatic t_shared;
    cfg(0, 2, 3, 8, 2);
    cfg(1, 4, 5, 8, 3);
    run_prog(2, 9);
    chk("R7 shared end visits", visits[8], 6);
    chk("R7 outer start visits", visits[3], 2);
    chk("R7 inner start visits", visits[5], 6);
    chk("R7 cycles", cycles, 31);
    chk("R7 both retired", end_active, 0);
  endtask

  task automatic t_full;
    cfg(0, 2, 3, 12, 2);
    cfg(1, 4, 5, 9, 2);
    cfg(2, 6, 7, 7, 5);
    run_prog(3, 13);
    chk("R8 third setup no redirect", setup_tgt, -1);
    chk("R8 ignored loop body visits", visits[7], 4);
    chk("R8 inner end visits", visits[9], 4);
    chk("R8 cycles", cycles, 33);
    chk("R8 active dropped", end_active, 0);
  endtask

  task automatic t_single_instr;
    cfg(0, 4, 5, 5, 40);
    run_prog(1, 6);
    chk("R9 one-instruction visits", visits[5], 40);
    chk("R9 loop-backs", loopbacks, 39);
    chk("R9 cycles", cycles, 45);
    chk("R9 active dropped", end_active, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_once();
    t_zero();
    t_nested();
    t_shared();
    t_full();
    t_single_instr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL global watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule